// File: doc/BRIEF.md
# Keypad PIN Lock Controller

This block sits behind a keypad scanner and decides whether a four-digit code opens a lock. Each cycle it may receive one decoded key event: a digit from 0 to 9, a clear key or a validate key. Digits fill the entry slots in the order they are pressed. Clear empties the entry. Validate starts a comparison of the entry against a secret that is fixed by a parameter. While the comparison runs, the block raises busy. When it finishes, it either pulses unlock for one cycle or raises an error indicator. The error indicator stays up until the next check begins.

A parameter chooses how the comparison spends its cycles. In early-exit mode, slots are examined from first to last, one per cycle, and the block stops at the first wrong slot. The error delay therefore shows how many leading digits were right. In constant-time mode, every slot is examined and the result always appears the same number of cycles after validate. This removes the timing hint about the mismatch position.

Top module: `pinlock_top`

## Requirements
- R1: A key event is taken when key_valid is high. Code values 0 to 9 are digits and fill the slots in press order. Code 10 is clear and code 11 is validate. Codes 12 to 15 are ignored.
- R2: After reset, err_led, unlock_pulse and busy are all low.
- R3: A validate accepted while busy is low sets busy high and err_led low in the next cycle.
- R4: A full match raises unlock_pulse for exactly one cycle, in the cycle busy falls, and err_led stays low.
- R5: In early-exit mode (CONST_TIME=0), let k be the first wrong slot, counted from 0. A mismatch raises err_led and drops busy k+1 cycles after the validate edge. A full match reports after DIGITS cycles.
- R6: In constant-time mode (CONST_TIME=1), the result always appears DIGITS cycles after the validate edge, wherever the mismatch lies.
- R7: Clear discards all digits entered so far.
- R8: Digits pressed after all DIGITS slots are full are ignored.
- R9: Validate with fewer than DIGITS digits reports an error, because empty slots count as mismatches.
- R10: busy is high from the cycle after validate until the result. Every key event that arrives while busy is high is dropped, including clear.
- R11: err_led holds until the next accepted validate. The entry is empty after every result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_valid | input | 1 | A key event is present this cycle |
| key_code | input | 4 | Key code: 0-9 digit, 10 clear, 11 validate |
| err_led | output | 1 | Error indicator, held until the next check starts |
| unlock_pulse | output | 1 | One-cycle pulse on a correct code |
| busy | output | 1 | Comparison in progress |

## Verification
The comparison is driven with several entries:
- the exact secret;
- entries wrong at each of the four positions in turn;
- a short entry;
- an entry with a clear in the middle;
- an entry with extra digits;
- an entry with ignored codes mixed in.

The bench instantiates an early-exit copy and a constant-time copy side by side, both driven by the same keys. For the early-exit copy, the measured latencies must separate every mismatch position. For the constant-time copy, the latency must be identical in every case. A clear pressed during busy is used to show that keys are dropped: if that clear were accepted, a correct entry would turn into an error at a different latency.

// File: rtl/pinlock_pkg.sv
package pinlock_pkg;

    localparam int          KEY_W    = 4;
    localparam logic [3:0]  CODE_CLR = 4'd10;
    localparam logic [3:0]  CODE_GO  = 4'd11;

    typedef enum logic [1:0] {
        EV_NONE,
        EV_DIGIT,
        EV_CLEAR,
        EV_CHECK
    } ev_kind_e;

    typedef struct packed {
        ev_kind_e          kind;
        logic [KEY_W-1:0]  val;
    } key_ev_t;

    typedef enum logic {
        SQ_IDLE,
        SQ_SCAN
    } seq_st_e;

    typedef struct packed {
        logic done;
        logic fail;
    } verdict_t;

    // Map a raw key code onto an event kind; reserved codes become no event
    function automatic key_ev_t classify(input logic v, input logic [KEY_W-1:0] code);
        key_ev_t e;
        e.val  = code;
        e.kind = EV_NONE;
        if (v) begin
            if (code < CODE_CLR)       e.kind = EV_DIGIT;
            else if (code == CODE_CLR) e.kind = EV_CLEAR;
            else if (code == CODE_GO)  e.kind = EV_CHECK;
        end
        return e;
    endfunction

endpackage

// File: rtl/pinlock_keydec.sv
module pinlock_keydec
    import pinlock_pkg::*;
(
    input  logic             key_valid,
    input  logic [KEY_W-1:0] key_code,
    input  logic             busy,
    output key_ev_t          ev
);
    // Events are suppressed entirely while a comparison is running
    always_comb begin
        ev = classify(key_valid, key_code);
        if (busy) ev.kind = EV_NONE;
    end
endmodule

// File: rtl/pinlock_entry.sv
module pinlock_entry
    import pinlock_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic                         clk,
    input  logic                         rst,
    input  key_ev_t                      ev,
    input  logic                         flush,
    output logic [DIGITS-1:0][KEY_W-1:0] slot_val,
    output logic [DIGITS-1:0]            slot_full
);
    localparam int CW = $clog2(DIGITS + 1);

    logic [CW-1:0] fill_cnt;
    logic          wipe;
    logic          take;

    assign wipe = flush || (ev.kind == EV_CLEAR);
    assign take = (ev.kind == EV_DIGIT) && (fill_cnt < CW'(DIGITS));

    always_ff @(posedge clk) begin
        if (rst || wipe)  fill_cnt <= '0;
        else if (take)    fill_cnt <= fill_cnt + 1'b1;
    end

    for (genvar i = 0; i < DIGITS; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (rst || wipe) begin
                slot_full[i] <= 1'b0;
                slot_val[i]  <= '0;
            end else if (take && (fill_cnt == CW'(i))) begin
                slot_full[i] <= 1'b1;
                slot_val[i]  <= ev.val;
            end
        end
    end
endmodule

// File: rtl/pinlock_seq.sv
module pinlock_seq
    import pinlock_pkg::*;
#(
    parameter int                      DIGITS     = 4,
    parameter logic [DIGITS*KEY_W-1:0] SECRET     = 16'h5982,
    parameter bit                      CONST_TIME = 1'b0
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic [DIGITS-1:0][KEY_W-1:0] slot_val,
    input  logic [DIGITS-1:0]            slot_full,
    output logic                         err_led,
    output logic                         unlock_pulse,
    output logic                         busy,
    output logic                         flush
);
    localparam int IW = (DIGITS > 1) ? $clog2(DIGITS) : 1;

    seq_st_e                    state;
    logic [IW-1:0]              idx;
    logic                       miss;
    logic                       cur_ok;
    logic                       last;
    verdict_t                   vd;
    logic [DIGITS-1:0][KEY_W-1:0] sec_dig;

    // First pressed digit sits in the most significant nibble of SECRET
    for (genvar i = 0; i < DIGITS; i++) begin : g_sec
        assign sec_dig[i] = SECRET[(DIGITS-1-i)*KEY_W +: KEY_W];
    end

    assign cur_ok = slot_full[idx] && (slot_val[idx] == sec_dig[idx]);
    assign last   = (idx == IW'(DIGITS - 1));

    if (CONST_TIME) begin : g_flat
        always_comb begin
            vd.done = (state == SQ_SCAN) && last;
            vd.fail = miss || !cur_ok;
        end
    end else begin : g_early
        always_comb begin
            vd.done = (state == SQ_SCAN) && (last || !cur_ok);
            vd.fail = !cur_ok;
        end
    end

    assign busy  = (state == SQ_SCAN);
    assign flush = vd.done;

    always_ff @(posedge clk) begin
        if (rst) begin
            state        <= SQ_IDLE;
            idx          <= '0;
            miss         <= 1'b0;
            err_led      <= 1'b0;
            unlock_pulse <= 1'b0;
        end else begin
            unlock_pulse <= 1'b0;
            case (state)
                SQ_IDLE: begin
                    if (start) begin
                        state   <= SQ_SCAN;
                        idx     <= '0;
                        miss    <= 1'b0;
                        err_led <= 1'b0;
                    end
                end
                SQ_SCAN: begin
                    if (vd.done) begin
                        state        <= SQ_IDLE;
                        err_led      <= vd.fail;
                        unlock_pulse <= !vd.fail;
                    end else begin
                        idx  <= idx + 1'b1;
                        miss <= miss || !cur_ok;
                    end
                end
                default: state <= SQ_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/pinlock_top.sv
module pinlock_top
    import pinlock_pkg::*;
#(
    parameter int                      DIGITS     = 4,
    parameter logic [DIGITS*KEY_W-1:0] SECRET     = 16'h5982,
    parameter bit                      CONST_TIME = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             key_valid,
    input  logic [KEY_W-1:0] key_code,
    output logic             err_led,
    output logic             unlock_pulse,
    output logic             busy
);
    key_ev_t                      ev;
    logic                         flush;
    logic [DIGITS-1:0][KEY_W-1:0] slot_val;
    logic [DIGITS-1:0]            slot_full;
    logic                         start;

    pinlock_keydec u_dec (
        .key_valid (key_valid),
        .key_code  (key_code),
        .busy      (busy),
        .ev        (ev)
    );

    pinlock_entry #(.DIGITS(DIGITS)) u_entry (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .flush     (flush),
        .slot_val  (slot_val),
        .slot_full (slot_full)
    );

    assign start = (ev.kind == EV_CHECK);

    pinlock_seq #(
        .DIGITS     (DIGITS),
        .SECRET     (SECRET),
        .CONST_TIME (CONST_TIME)
    ) u_seq (
        .clk          (clk),
        .rst          (rst),
        .start        (start),
        .slot_val     (slot_val),
        .slot_full    (slot_full),
        .err_led      (err_led),
        .unlock_pulse (unlock_pulse),
        .busy         (busy),
        .flush        (flush)
    );
endmodule

// File: rtl/pinlock_chk.sv
module pinlock_chk #(
    parameter int DIGITS     = 4,
    parameter bit CONST_TIME = 1'b0
) (
    input logic       clk,
    input logic       rst,
    input logic       key_valid,
    input logic [3:0] key_code,
    input logic       err_led,
    input logic       unlock_pulse,
    input logic       busy
);
    logic [7:0] busy_cnt;
    logic       go_taken;

    assign go_taken = key_valid && (key_code == 4'd11) && !busy;

    always_ff @(posedge clk) begin
        if (rst)                   busy_cnt <= '0;
        else if (!busy)            busy_cnt <= '0;
        else if (busy_cnt != 8'hFF) busy_cnt <= busy_cnt + 1'b1;
    end

    // R3: an accepted validate starts a check with the error cleared
    p_start_r3: assert property (@(posedge clk) disable iff (rst)
        go_taken |=> (busy && !err_led));

    // R4: unlock lasts a single cycle and never coexists with error
    p_pulse_r4: assert property (@(posedge clk) disable iff (rst)
        unlock_pulse |=> !unlock_pulse);
    p_excl_r4: assert property (@(posedge clk) disable iff (rst)
        !(unlock_pulse && err_led));

    // R10: busy only ends with a verdict
    p_verdict_r10: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (err_led || unlock_pulse));

    // R6: constant-time mode always takes DIGITS cycles
    p_flat_r6: assert property (@(posedge clk) disable iff (rst)
        (CONST_TIME && $fell(busy)) |-> (busy_cnt == 8'(DIGITS)));

    // R5: early-exit mode never exceeds DIGITS cycles
    p_early_r5: assert property (@(posedge clk) disable iff (rst)
        (!CONST_TIME && $fell(busy)) |-> (busy_cnt >= 8'd1 && busy_cnt <= 8'(DIGITS)));

    // R11: error holds until a new check is accepted
    p_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (err_led && !go_taken) |=> err_led);
endmodule

bind pinlock_top pinlock_chk #(.DIGITS(DIGITS), .CONST_TIME(CONST_TIME)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .key_valid    (key_valid),
    .key_code     (key_code),
    .err_led      (err_led),
    .unlock_pulse (unlock_pulse),
    .busy         (busy)
);

// File: tb/sim_pinlock_top.sv
`timescale 1ns/1ps
module sim_pinlock_top;
    localparam logic [15:0] SECRET = 16'h5982;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       key_valid = 1'b0;
    logic [3:0] key_code = 4'd0;
    logic       err0, unl0, busy0;
    logic       err1, unl1, busy1;

    int n_chk  = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pinlock_top #(.DIGITS(4), .SECRET(SECRET), .CONST_TIME(1'b0)) u0 (
        .clk(clk), .rst(rst), .key_valid(key_valid), .key_code(key_code),
        .err_led(err0), .unlock_pulse(unl0), .busy(busy0));

    pinlock_top #(.DIGITS(4), .SECRET(SECRET), .CONST_TIME(1'b1)) u1 (
        .clk(clk), .rst(rst), .key_valid(key_valid), .key_code(key_code),
        .err_led(err1), .unlock_pulse(unl1), .busy(busy1));

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [3:0] sec_at(input int i);
        return SECRET[(3-i)*4 +: 4];
    endfunction

    task automatic press(input logic [3:0] c);
        @(negedge clk);
        key_valid = 1'b1;
        key_code  = c;
        @(negedge clk);
        key_valid = 1'b0;
        key_code  = 4'd0;
    endtask

    // Enters n codes, validates, and checks both copies against a model of R1/R7/R8/R9
    task automatic attempt(input int n, input logic [3:0] s0, s1, s2, s3, s4, s5,
                           input string tag);
        logic [3:0] sq [6];
        logic [3:0] ent [4];
        int cnt = 0;
        int bad = 4;
        int lat0 = -1, lat1 = -1;
        bit e0 = 0, e1 = 0, q0 = 0, q1 = 0;
        bit experr;
        int explat0;
        sq = '{s0, s1, s2, s3, s4, s5};
        for (int i = 0; i < n; i++) begin
            press(sq[i]);
            if (sq[i] < 4'd10 && cnt < 4) begin ent[cnt] = sq[i]; cnt++; end
            else if (sq[i] == 4'd10) cnt = 0;
        end
        for (int i = 0; i < 4; i++)
            if (bad == 4 && (i >= cnt || ent[i] != sec_at(i))) bad = i;
        experr  = (bad < 4);
        explat0 = experr ? bad + 1 : 4;
        press(4'd11);
        check(busy0 && busy1, {tag, " R3"}, "busy after validate", int'(busy0 & busy1), 1);
        check(!err0 && !err1, {tag, " R3"}, "err cleared at start", int'(err0 | err1), 0);
        for (int c = 1; c <= 6; c++) begin
            @(negedge clk);
            if (q0) begin check(!unl0, {tag, " R4"}, "unlock width u0", int'(unl0), 0); q0 = 0; end
            if (q1) begin check(!unl1, {tag, " R4"}, "unlock width u1", int'(unl1), 0); q1 = 0; end
            if (lat0 < 0 && !busy0) begin lat0 = c; e0 = err0; q0 = unl0;
                check(unl0 == !experr, {tag, " R4"}, "unlock u0", int'(unl0), int'(!experr)); end
            if (lat1 < 0 && !busy1) begin lat1 = c; e1 = err1; q1 = unl1;
                check(unl1 == !experr, {tag, " R4"}, "unlock u1", int'(unl1), int'(!experr)); end
        end
        check(e0 == experr, {tag, " R9"}, "err u0", int'(e0), int'(experr));
        check(e1 == experr, {tag, " R9"}, "err u1", int'(e1), int'(experr));
        check(lat0 == explat0, {tag, " R5"}, "early latency", lat0, explat0);
        check(lat1 == 4, {tag, " R6"}, "const latency", lat1, 4);
        check(err0 == experr && err1 == experr, {tag, " R11"}, "err held",
              int'(err0 & err1), int'(experr));
    endtask

    // R10: a clear pressed during the scan must not disturb a correct entry
    task automatic busy_drop();
        int lat0 = -1;
        bit got = 0;
        press(4'd5); press(4'd9); press(4'd8); press(4'd2);
        @(negedge clk);
        key_valid = 1'b1; key_code = 4'd11;
        @(negedge clk);
        key_code = 4'd10;
        @(negedge clk);
        key_valid = 1'b0; key_code = 4'd0;
        for (int c = 2; c <= 6; c++) begin
            @(negedge clk);
            if (lat0 < 0 && !busy0) begin lat0 = c; got = unl0; end
        end
        check(got == 1'b1, "R10", "unlock despite clear in busy", int'(got), 1);
        check(lat0 == 4, "R10", "latency with clear in busy", lat0, 4);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            n_chk++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(!err0 && !unl0 && !busy0 && !err1 && !unl1 && !busy1, "R2",
              "reset outputs", int'(err0 | unl0 | busy0 | err1 | unl1 | busy1), 0);
        attempt(4, 4'd5, 4'd9, 4'd8, 4'd2, 4'd0, 4'd0, "match");
        attempt(4, 4'd1, 4'd9, 4'd8, 4'd2, 4'd0, 4'd0, "wrong0");
        attempt(4, 4'd5, 4'd0, 4'd8, 4'd2, 4'd0, 4'd0, "wrong1");
        attempt(4, 4'd5, 4'd9, 4'd7, 4'd2, 4'd0, 4'd0, "wrong2");
        attempt(4, 4'd5, 4'd9, 4'd8, 4'd3, 4'd0, 4'd0, "wrong3");
        attempt(3, 4'd5, 4'd9, 4'd8, 4'd0, 4'd0, 4'd0, "short R9");
        attempt(6, 4'd1, 4'd2, 4'd10, 4'd5, 4'd9, 4'd8, "clear R7");
        attempt(1, 4'd2, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, "after clear R7");
        attempt(5, 4'd5, 4'd9, 4'd8, 4'd2, 4'd7, 4'd0, "extra R8");
        attempt(6, 4'd5, 4'd13, 4'd9, 4'd15, 4'd8, 4'd2, "reserved R1");
        attempt(0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, "empty R11");
        busy_drop();
        attempt(0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, 4'd0, "flushed R11");
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    end
endmodule